// File: doc/BRIEF.md
# Multicast Lookup RAM Write Port

This block is one core's slice of a lookup RAM, together with the logic that lets remote cores write into it. The storage has two ports. The read port belongs to the local streamer. It presents a word address every cycle and receives the stored word one clock edge later. A write is never allowed to hold it up. The write port is shared by two kinds of writer: a set of remote sources on a common write bus, and the local core's own write request.

Each remote source drives a 42-bit channel and a destination mask with one bit per core. A single remote write can target several cores at once. Every core whose mask bit is set performs the same write in the same cycle. This slice reacts only to its own mask bit, which is selected by a parameter. Remote writes always beat the local writer. When several remote sources hit this slice together, the lowest-numbered one is granted. The losers are told to stall and present their write again on the next cycle.

Top module: `lram_mcast_slice`

## Requirements
- R1: A remote channel is laid out as write-enable in bit 41, word address in bits 40:32 and data in bits 31:0. A channel with bit 41 set and the mask bit numbered CORE_ID set stores its data at its address.
- R2: A remote channel whose write-enable is clear, or whose mask does not include bit CORE_ID, changes no stored word.
- R3: When several remote sources hit this slice in one cycle, only the lowest-numbered one writes. Every other hitting source sees its bit of rmt_stall_o high in that same cycle, and sources that do not hit never see it high. A stalled source that retries alone on the next cycle is written.
- R4: A local write request in a cycle with no remote hit is stored, and lcl_stall_o stays low.
- R5: A local write request in a cycle with a remote hit is not stored. lcl_stall_o is high in that cycle. The request succeeds when it is retried on a later cycle with no remote hit.
- R6: rd_data_o shows the word at the rd_addr_i presented before the previous clock edge. Back-to-back reads return one word per cycle, even while writes are being stored.
- R7: A read of an address in the same cycle it is written returns the old word. The new word is returned from the next cycle on.
- R8: While rst_n is low, rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rmt_chan_i | input | NSRC*42 | Remote write channels; source s occupies bits s*42 upward |
| rmt_mask_i | input | NSRC*NCORE | Destination masks; source s occupies bits s*NCORE upward |
| rmt_stall_o | output | NSRC | Per-source stall: the write hit this slice but lost arbitration |
| lcl_wr_en_i | input | 1 | Local write request |
| lcl_addr_i | input | 9 | Local write word address |
| lcl_data_i | input | 32 | Local write data |
| lcl_stall_o | output | 1 | Local request lost to a remote write this cycle |
| rd_addr_i | input | 9 | Streamer read word address |
| rd_data_o | output | 32 | Streamer read data, one cycle after the address |

## Verification
Both stall outputs are combinational. The bench drives a stimulus just after a falling edge and checks the stall flags shortly afterwards, inside the same cycle. Writes land on the next rising edge. Read data becomes valid after the rising edge that follows the address. The driver therefore queues each expected word tagged with the cycle number in which it is due, and the monitor compares it at the falling edge of that cycle. A read issued in the same cycle as a write to that address is queued with the old word.

// File: rtl/lram_pkg.sv
package lram_pkg;
    localparam int AW  = 9;
    localparam int DW  = 32;
    localparam int CHW = 1 + AW + DW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } chan_t;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wcmd_t;
endpackage

// File: rtl/lram_dest_decode.sv
module lram_dest_decode
    import lram_pkg::*;
#(
    parameter int NSRC    = 4,
    parameter int NCORE   = 8,
    parameter int CORE_ID = 2
) (
    input  logic [NSRC*CHW-1:0]   chan_i,
    input  logic [NSRC*NCORE-1:0] mask_i,
    output chan_t                 ch_o [NSRC],
    output logic [NSRC-1:0]       hit_o
);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign ch_o[s]  = chan_t'(chan_i[s*CHW +: CHW]);
        assign hit_o[s] = ch_o[s].we & mask_i[s*NCORE + CORE_ID];
    end
endmodule

// File: rtl/lram_write_arb.sv
module lram_write_arb
    import lram_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            [NSRC-1:0] hit_i,
    input  chan_t                      ch_i [NSRC],
    input  logic                       lcl_en_i,
    input  logic [AW-1:0]              lcl_addr_i,
    input  logic [DW-1:0]              lcl_data_i,
    output wcmd_t                      wcmd_o,
    output logic            [NSRC-1:0] rmt_stall_o,
    output logic                       lcl_stall_o
);
    logic [NSRC-1:0] grant;
    logic            any_hit;

    always_comb begin
        any_hit = |hit_i;
        grant   = hit_i & (~hit_i + NSRC'(1));
        wcmd_o  = '{en: 1'b0, addr: lcl_addr_i, data: lcl_data_i};
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (grant[s]) begin
                wcmd_o = '{en: 1'b1, addr: ch_i[s].addr, data: ch_i[s].data};
            end
        end
        if (!any_hit && lcl_en_i) begin
            wcmd_o.en = 1'b1;
        end
        rmt_stall_o = hit_i & ~grant;
        lcl_stall_o = lcl_en_i & any_hit;
    end
endmodule

// File: rtl/lram_store.sv
module lram_store
    import lram_pkg::*;
#(
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wcmd_t         wcmd_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);
    typedef struct packed {
        logic [DW-1:0] rd_data;
    } st_t;

    logic [DW-1:0] mem [DEPTH];
    st_t           st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rd_data = mem[rd_addr_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wcmd_i.en) mem[wcmd_i.addr] <= wcmd_i.data;
    end

    assign rd_data_o = st_q.rd_data;
endmodule

// File: rtl/lram_mcast_slice.sv
module lram_mcast_slice
    import lram_pkg::*;
#(
    parameter int NSRC    = 4,
    parameter int NCORE   = 8,
    parameter int CORE_ID = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC*CHW-1:0]    rmt_chan_i,
    input  logic [NSRC*NCORE-1:0]  rmt_mask_i,
    output logic [NSRC-1:0]        rmt_stall_o,
    input  logic                   lcl_wr_en_i,
    input  logic [AW-1:0]          lcl_addr_i,
    input  logic [DW-1:0]          lcl_data_i,
    output logic                   lcl_stall_o,
    input  logic [AW-1:0]          rd_addr_i,
    output logic [DW-1:0]          rd_data_o
);
    chan_t           rmt_ch [NSRC];
    logic [NSRC-1:0] rmt_hit;
    wcmd_t           wcmd;

    lram_dest_decode #(.NSRC(NSRC), .NCORE(NCORE), .CORE_ID(CORE_ID)) u_dec (
        .chan_i (rmt_chan_i),
        .mask_i (rmt_mask_i),
        .ch_o   (rmt_ch),
        .hit_o  (rmt_hit)
    );

    lram_write_arb #(.NSRC(NSRC)) u_arb (
        .hit_i       (rmt_hit),
        .ch_i        (rmt_ch),
        .lcl_en_i    (lcl_wr_en_i),
        .lcl_addr_i  (lcl_addr_i),
        .lcl_data_i  (lcl_data_i),
        .wcmd_o      (wcmd),
        .rmt_stall_o (rmt_stall_o),
        .lcl_stall_o (lcl_stall_o)
    );

    lram_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wcmd_i    (wcmd),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/lram_mcast_slice_chk.sv
module lram_mcast_slice_chk #(
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] hit,
    input logic [NSRC-1:0] rmt_stall,
    input logic            lcl_en,
    input logic            lcl_stall,
    input logic            wr_en
);
    // R3
    stall_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_stall & ~hit) == '0);
    // R3
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> ($countones(rmt_stall) == $countones(hit) - 1));
    // R5
    lcl_stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_stall |-> (lcl_en && (|hit)));
    // R4
    lcl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_en && !(|hit)) |-> !lcl_stall);
    // R2
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit) && !lcl_en) |-> !wr_en);
endmodule

bind lram_mcast_slice lram_mcast_slice_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (rmt_hit),
    .rmt_stall (rmt_stall_o),
    .lcl_en    (lcl_wr_en_i),
    .lcl_stall (lcl_stall_o),
    .wr_en     (wcmd.en)
);

// File: tb/tb_lram_mcast_slice.sv
module tb_lram_mcast_slice;
    localparam int NSRC = 4, NCORE = 8, CORE_ID = 2, AW = 9, DW = 32;
    localparam int CHW = 1 + AW + DW;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NSRC*CHW-1:0]   rmt_chan = '0;
    logic [NSRC*NCORE-1:0] rmt_mask = '0;
    logic [NSRC-1:0]       rmt_stall;
    logic                  lcl_en = 1'b0;
    logic [AW-1:0]         lcl_addr = '0;
    logic [DW-1:0]         lcl_data = '0;
    logic                  lcl_stall;
    logic [AW-1:0]         rd_addr = '0;
    logic [DW-1:0]         rd_data;

    lram_mcast_slice #(.NSRC(NSRC), .NCORE(NCORE), .CORE_ID(CORE_ID)) dut (
        .clk(clk), .rst_n(rst_n), .rmt_chan_i(rmt_chan), .rmt_mask_i(rmt_mask),
        .rmt_stall_o(rmt_stall), .lcl_wr_en_i(lcl_en), .lcl_addr_i(lcl_addr),
        .lcl_data_i(lcl_data), .lcl_stall_o(lcl_stall), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    nvec = 0;
    int    nbad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            cmp(it.tag, rd_data, it.exp);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_src(int s, logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic [NCORE-1:0] m);
        rmt_chan[s*CHW +: CHW]   = {we, a, d};
        rmt_mask[s*NCORE +: NCORE] = m;
    endtask

    task automatic idle();
        rmt_chan = '0;
        rmt_mask = '0;
        lcl_en   = 1'b0;
    endtask

    task automatic lcl(logic [AW-1:0] a, logic [DW-1:0] d);
        lcl_en = 1'b1; lcl_addr = a; lcl_data = d;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
        item_t it;
        rd_addr = a;
        it.due = cyc + 1; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) step();
        cmp("R8 reset data", rd_data, 32'h0);
        rst_n = 1'b1;
        step();

        // R4 local writes with no remote traffic
        lcl(6, 32'h66); #1 cmp("R4 lcl_stall", 32'(lcl_stall), 0); step();
        lcl(7, 32'h77); step();
        lcl(20, 32'h2020); step();
        idle();
        rd(6, 32'h66, "R4 read 6"); step();
        rd(7, 32'h77, "R4 read 7"); step();
        rd(20, 32'h2020, "R4 read 20"); step();

        // R1 multicast write including this core
        set_src(1, 1'b1, 5, 32'hA5A5_0001, 8'b0010_0100); step();
        idle();
        rd(5, 32'hA5A5_0001, "R1 multicast write"); step();

        // R2 mask misses this core / write-enable clear
        set_src(0, 1'b1, 6, 32'hBAD0, 8'b0000_1000);
        set_src(3, 1'b0, 7, 32'hBAD1, 8'b0000_0100);
        #1 cmp("R2 no stall", 32'(rmt_stall), 0);
        step(); idle();
        rd(6, 32'h66, "R2 mask miss"); step();
        rd(7, 32'h77, "R2 we clear"); step();

        // R3 two hitting sources, one non-hitting
        set_src(1, 1'b1, 10, 32'h111, 8'b0000_0100);
        set_src(2, 1'b1, 10, 32'h222, 8'b0000_1000);
        set_src(3, 1'b1, 10, 32'h333, 8'b1111_1111);
        #1 cmp("R3 stall vector", 32'(rmt_stall), 32'b1000);
        step(); idle();
        set_src(3, 1'b1, 10, 32'h333, 8'b1111_1111);
        #1 cmp("R3 retry no stall", 32'(rmt_stall), 0);
        rd(10, 32'h111, "R3 R7 winner old word during write"); step();
        idle();
        rd(10, 32'h333, "R3 retried write"); step();

        // R5 local loses to remote
        lcl(20, 32'hC0DE);
        set_src(2, 1'b1, 21, 32'h2121, 8'b0000_0100);
        #1 cmp("R5 lcl_stall high", 32'(lcl_stall), 1);
        cmp("R5 remote not stalled", 32'(rmt_stall), 0);
        step();
        set_src(2, 1'b0, 0, 0, 0);
        #1 cmp("R5 retry lcl_stall low", 32'(lcl_stall), 0);
        rd(20, 32'h2020, "R5 R7 old word before retry"); step();
        idle();
        rd(20, 32'hC0DE, "R5 retried local"); step();
        rd(21, 32'h2121, "R5 remote word"); step();

        // R6 back-to-back reads under concurrent writes
        for (int i = 0; i < 8; i++) begin
            lcl(AW'(100 + i), 32'h1000 + i); step();
        end
        idle();
        for (int i = 0; i < 8; i++) begin
            set_src(0, 1'b1, AW'(200 + i), 32'h2000 + i, 8'b0000_0100);
            rd(AW'(100 + i), 32'h1000 + i, "R6 streamed read"); step();
        end
        idle();
        for (int i = 0; i < 8; i++) begin
            rd(AW'(200 + i), 32'h2000 + i, "R6 R1 streamed remote word"); step();
        end
        step(); step();
        if (sb.size() != 0) begin
            nbad++;
            $display("FAIL R6: actual %0d pending expected 0", sb.size());
        end
        summary();
        $finish;
    end
endmodule